// File: doc/BRIEF.md
# USB Controller Interrupt Status Unit

This block holds the global interrupt status word and its enable mask for a USB controller that can act as host or device. Six status bits are sticky: a one-cycle pulse from the protocol core sets them, and they stay set until software writes 1 to them. The other status bits are live levels sampled each cycle: receive-FIFO occupancy, a transmit-empty indication with a selectable threshold, the OR of the OTG sub-status, the two global-NAK-effective flags and the current role. The single interrupt line is the registered OR of every enabled status bit.

The block also checks every register access against the current role. An access that lands in the host-only address range while the controller is a device, or in the device-only range while it is a host, is flagged on `acc_drop` in the same cycle. The surrounding register fabric then discards it, and the block latches the mode-mismatch status bit. The register port has no back-pressure. A request is taken in any cycle where `reg_valid` is high, and `rsp_valid` with `rsp_data` follows exactly one cycle later for every request, reads and writes alike.

Top module: `usb_irq_status_unit`

## Requirements
- R1: After reset, the status word reads 0x0000_0020 when the TX FIFO is empty, the queue has room and the role is device. The mask reads 0 and `irq` is 0. Bits 31:14 and 9:8 of any read are 0.
- R2: The sticky bits are 13 (enumeration done), 12 (bus reset), 11 (suspend), 10 (early suspend), 3 (start of frame) and 1 (mode mismatch). Each is set by its event and cleared only when a 1 is written to its position in the status word (address STS_ADDR). Writing 0 leaves it unchanged.
- R3: When a set event and a write-1 clear reach the same sticky bit in the same cycle, the bit ends at 1.
- R4: Bit 4 follows `rx_pkt_pending`, one cycle later.
- R5: Bit 5 is 1 when `txq_has_room` is 1 and the FIFO fill condition holds. With `txe_full_sel`=0 the condition is `txf_used` <= TXF_DEPTH/2. With `txe_full_sel`=1 it is `txf_used` == 0. The bit is visible one cycle later and resets to 1.
- R6: Bit 2 is the OR of `otg_sub_status`. It is read-only, so writing 1 to it has no effect.
- R7: Bit 7 follows `gout_nak_eff`, bit 6 follows `gin_nak_eff` and bit 0 follows `host_mode` (0 = device, 1 = host), each one cycle later. All three are read-only.
- R8: An access in [HOST_LO, HOST_HI] with `host_mode`=0, or in [DEV_LO, DEV_HI] with `host_mode`=1, drives `acc_drop` high in the same cycle, returns read data 0 and sets bit 1. Accesses to the status and mask addresses never do this.
- R9: The mask at MSK_ADDR keeps only bits 13:10 and 7:1. A masked-off bit still sets in the status word. `irq` equals the OR of status AND mask as seen one cycle earlier.
- R10: `rsp_valid` is high exactly one cycle after each request. For a read, `rsp_data` holds the register value from before that cycle's edge. It is 0 for any address other than the status and mask addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_valid | input | 1 | Register request present |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for previous-cycle request |
| rsp_data | output | 32 | Read data |
| acc_drop | output | 1 | Current request is role-mismatched; discard it |
| ev_enum_done | input | 1 | Speed enumeration complete pulse |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_suspend | input | 1 | Suspend detected pulse |
| ev_early_suspend | input | 1 | Idle-bus early warning pulse |
| ev_sof | input | 1 | Start of frame pulse |
| rx_pkt_pending | input | 1 | Receive FIFO holds a packet |
| txf_used | input | TXF_CW | TX FIFO words occupied |
| txq_has_room | input | 1 | TX request queue has a free entry |
| txe_full_sel | input | 1 | 1 = completely-empty threshold, 0 = half-empty |
| otg_sub_status | input | OTG_W | OTG sub-status bits |
| gout_nak_eff | input | 1 | Global OUT NAK in force |
| gin_nak_eff | input | 1 | Global IN NAK in force |
| host_mode | input | 1 | Current role, 1 = host |
| irq | output | 1 | Interrupt request |

## Verification
A sticky bit that fails to hold, or that clears on a 0 write, shows on the next status read, which comes two cycles after the event. A mask bit stuck at the wrong value shows on `irq` one cycle after the status bit it gates changes. A wrong transmit-empty threshold appears only when `txf_used` sits at exactly TXF_DEPTH/2 or at 1, so those values are driven in both threshold settings. A broken range decode shows in the same cycle on `acc_drop`, and a cycle later in the mismatch bit.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int B_CMODE = 0;
  localparam int B_MMIS  = 1;
  localparam int B_OTG   = 2;
  localparam int B_SOF   = 3;
  localparam int B_RXNE  = 4;
  localparam int B_TXE   = 5;
  localparam int B_INAK  = 6;
  localparam int B_ONAK  = 7;
  localparam int B_ESUSP = 10;
  localparam int B_SUSP  = 11;
  localparam int B_BRST  = 12;
  localparam int B_ENUM  = 13;

  localparam int NUM_EV = 6;
  // sticky bit index -> status bit position
  localparam int EV_POS [NUM_EV] = '{B_ENUM, B_BRST, B_SUSP, B_ESUSP, B_SOF, B_MMIS};

  localparam logic [31:0] MASKABLE = 32'h0000_3CFE;

  typedef enum logic {ROLE_DEV = 1'b0, ROLE_HOST = 1'b1} role_e;
endpackage

// File: rtl/usbirq_event_bank.sv
module usbirq_event_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/usbirq_level_sampler.sv
module usbirq_level_sampler #(
  parameter int TXF_DEPTH = 16,
  parameter int OTG_W     = 8,
  localparam int TXF_CW   = $clog2(TXF_DEPTH + 1),
  localparam int HALF     = TXF_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pkt_pending,
  input  logic [TXF_CW-1:0] txf_used,
  input  logic              txq_has_room,
  input  logic              txe_full_sel,
  input  logic [OTG_W-1:0]  otg_sub_status,
  input  logic              gout_nak_eff,
  input  logic              gin_nak_eff,
  input  logic              host_mode,
  output logic              rxne_q,
  output logic              txe_q,
  output logic              otg_q,
  output logic              onak_q,
  output logic              inak_q,
  output logic              mode_q
);
  logic fill_ok;
  logic txe_d;

  always_comb begin
    if (txe_full_sel) fill_ok = (txf_used == '0);
    else              fill_ok = (txf_used <= TXF_CW'(HALF));
    txe_d = fill_ok && txq_has_room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxne_q <= 1'b0;
      txe_q  <= 1'b1;
      otg_q  <= 1'b0;
      onak_q <= 1'b0;
      inak_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      rxne_q <= rx_pkt_pending;
      txe_q  <= txe_d;
      otg_q  <= |otg_sub_status;
      onak_q <= gout_nak_eff;
      inak_q <= gin_nak_eff;
      mode_q <= host_mode;
    end
  end
endmodule

// File: rtl/usbirq_mode_guard.sv
module usbirq_mode_guard #(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] HOST_LO = 12'h400,
  parameter logic [ADDR_W-1:0] HOST_HI = 12'h7FF,
  parameter logic [ADDR_W-1:0] DEV_LO  = 12'h800,
  parameter logic [ADDR_W-1:0] DEV_HI  = 12'hBFF
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              host_mode,
  output logic              mismatch_o
);
  import usbirq_pkg::*;
  logic in_host, in_dev;
  role_e role;

  always_comb begin
    role      = role_e'(host_mode);
    in_host   = (addr >= HOST_LO) && (addr <= HOST_HI);
    in_dev    = (addr >= DEV_LO)  && (addr <= DEV_HI);
    mismatch_o = req_valid &&
                 (((role == ROLE_DEV)  && in_host) ||
                  ((role == ROLE_HOST) && in_dev));
  end
endmodule

// File: rtl/usb_irq_status_unit.sv
module usb_irq_status_unit #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 12'h014,
  parameter logic [ADDR_W-1:0] MSK_ADDR  = 12'h018,
  parameter logic [ADDR_W-1:0] HOST_LO   = 12'h400,
  parameter logic [ADDR_W-1:0] HOST_HI   = 12'h7FF,
  parameter logic [ADDR_W-1:0] DEV_LO    = 12'h800,
  parameter logic [ADDR_W-1:0] DEV_HI    = 12'hBFF,
  parameter int                TXF_DEPTH = 16,
  parameter int                OTG_W     = 8,
  localparam int               TXF_CW    = $clog2(TXF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              acc_drop,
  input  logic              ev_enum_done,
  input  logic              ev_bus_reset,
  input  logic              ev_suspend,
  input  logic              ev_early_suspend,
  input  logic              ev_sof,
  input  logic              rx_pkt_pending,
  input  logic [TXF_CW-1:0] txf_used,
  input  logic              txq_has_room,
  input  logic              txe_full_sel,
  input  logic [OTG_W-1:0]  otg_sub_status,
  input  logic              gout_nak_eff,
  input  logic              gin_nak_eff,
  input  logic              host_mode,
  output logic              irq
);
  import usbirq_pkg::*;

  logic [NUM_EV-1:0] ev_set, ev_clr, ev_q;
  logic rxne_q, txe_q, otg_q, onak_q, inak_q, mode_q;
  logic [31:0] sts_word, msk_q, rd_mux;
  logic sts_wr, msk_wr;

  usbirq_mode_guard #(
    .ADDR_W(ADDR_W), .HOST_LO(HOST_LO), .HOST_HI(HOST_HI),
    .DEV_LO(DEV_LO), .DEV_HI(DEV_HI)
  ) u_guard (
    .req_valid (reg_valid),
    .addr      (reg_addr),
    .host_mode (host_mode),
    .mismatch_o(acc_drop)
  );

  usbirq_level_sampler #(.TXF_DEPTH(TXF_DEPTH), .OTG_W(OTG_W)) u_lvl (
    .clk, .rst_n,
    .rx_pkt_pending, .txf_used, .txq_has_room, .txe_full_sel,
    .otg_sub_status, .gout_nak_eff, .gin_nak_eff, .host_mode,
    .rxne_q, .txe_q, .otg_q, .onak_q, .inak_q, .mode_q
  );

  always_comb begin
    sts_wr = reg_valid && reg_write && (reg_addr == STS_ADDR);
    msk_wr = reg_valid && reg_write && (reg_addr == MSK_ADDR);
    ev_set = {ev_enum_done, ev_bus_reset, ev_suspend, ev_early_suspend, ev_sof, acc_drop};
    for (int i = 0; i < NUM_EV; i++) begin
      ev_clr[NUM_EV-1-i] = sts_wr && reg_wdata[EV_POS[i]];
    end
  end

  // ev_set packs index 0 (enum done) at the MSB, so reverse into bank order
  logic [NUM_EV-1:0] set_ord, clr_ord;
  always_comb begin
    for (int i = 0; i < NUM_EV; i++) begin
      set_ord[i] = ev_set[NUM_EV-1-i];
      clr_ord[i] = ev_clr[NUM_EV-1-i];
    end
  end

  usbirq_event_bank #(.N(NUM_EV)) u_ev (
    .clk, .rst_n, .set_i(set_ord), .clr_i(clr_ord), .q_o(ev_q)
  );

  always_comb begin
    sts_word = '0;
    for (int i = 0; i < NUM_EV; i++) sts_word[EV_POS[i]] = ev_q[i];
    sts_word[B_CMODE] = mode_q;
    sts_word[B_OTG]   = otg_q;
    sts_word[B_RXNE]  = rxne_q;
    sts_word[B_TXE]   = txe_q;
    sts_word[B_INAK]  = inak_q;
    sts_word[B_ONAK]  = onak_q;
  end

  always_comb begin
    if (reg_addr == STS_ADDR)      rd_mux = sts_word;
    else if (reg_addr == MSK_ADDR) rd_mux = msk_q;
    else                           rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q     <= '0;
      irq       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (msk_wr) msk_q <= reg_wdata & MASKABLE;
      irq       <= |(sts_word & msk_q);
      rsp_valid <= reg_valid;
      rsp_data  <= (reg_valid && !reg_write && !acc_drop) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/usbirq_checker.sv
module usbirq_checker #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h014,
  parameter logic [ADDR_W-1:0] HOST_LO  = 12'h400,
  parameter logic [ADDR_W-1:0] HOST_HI  = 12'h7FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              host_mode,
  input logic              ev_enum_done,
  input logic              acc_drop,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic              irq,
  input logic [31:0]       sts_word,
  input logic [31:0]       msk_q
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[31:14] == '0 && rsp_data[9:8] == 2'b00));

  a_r2_enum_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_word[13]) &&
     !$past(reg_valid && reg_write && reg_addr == STS_ADDR && reg_wdata[13]))
    |-> sts_word[13]);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enum_done |=> sts_word[13]);

  a_r8_host_range_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !host_mode && reg_addr >= HOST_LO && reg_addr <= HOST_HI)
    |-> acc_drop);

  a_r8_mismatch_latched: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> sts_word[1]);

  a_r8_status_never_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_addr == STS_ADDR) |-> !acc_drop);

  a_r8_dropped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && acc_drop) |=> rsp_data == '0);

  a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |=> !irq);

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |=> rsp_valid);

  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |=> !rsp_valid);
endmodule

bind usb_irq_status_unit usbirq_checker #(
  .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .HOST_LO(HOST_LO), .HOST_HI(HOST_HI)
) u_chk (
  .clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_wdata, .host_mode,
  .ev_enum_done, .acc_drop, .rsp_valid, .rsp_data, .irq, .sts_word, .msk_q
);

// File: tb/sim_usb_irq_status_unit.sv
module sim_usb_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [11:0] STS = 12'h014, MSK = 12'h018;

  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_write = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic rsp_valid, acc_drop, irq;
  logic [31:0] rsp_data;
  logic ev_enum_done = 0, ev_bus_reset = 0, ev_suspend = 0, ev_early_suspend = 0, ev_sof = 0;
  logic rx_pkt_pending = 0, txq_has_room = 1, txe_full_sel = 0;
  logic [CW-1:0] txf_used = '0;
  logic [7:0] otg_sub_status = '0;
  logic gout_nak_eff = 0, gin_nak_eff = 0, host_mode = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_status_unit u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic drop);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    #1 drop = acc_drop;
    @(negedge clk);
    reg_valid = 0;
    d = rsp_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_sts(string tag, logic [31:0] exp);
    logic [31:0] d; logic dr;
    @(negedge clk);
    rd(STS, d, dr);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic dr;
    rd(STS, d, dr);  chk("R1 status reset", d, 32'h20);
    chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    rd(MSK, d, dr);  chk("R1 mask reset", d, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 rsp idle", {31'b0, rsp_valid}, 32'h0);
    rd(12'h01C, d, dr); chk("R10 unmapped reads 0", d, 32'h0);
  endtask

  task automatic t_sticky;
    @(negedge clk); ev_sof = 1;
    @(negedge clk); ev_sof = 0;
    rd_sts("R2 sof set", 32'h28);
    wr(STS, 32'h0);
    rd_sts("R2 zero write keeps", 32'h28);
    wr(STS, 32'h8);
    rd_sts("R2 w1c sof", 32'h20);
    @(negedge clk); ev_enum_done = 1; ev_bus_reset = 1; ev_suspend = 1; ev_early_suspend = 1;
    @(negedge clk); ev_enum_done = 0; ev_bus_reset = 0; ev_suspend = 0; ev_early_suspend = 0;
    rd_sts("R2 four events", 32'h3C20);
    wr(STS, 32'h3000);
    rd_sts("R2 partial clear", 32'h0C20);
    wr(STS, 32'h0C00);
    rd_sts("R2 all clear", 32'h20);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    ev_enum_done = 1; reg_valid = 1; reg_write = 1; reg_addr = STS; reg_wdata = 32'h2000;
    @(negedge clk);
    ev_enum_done = 0; reg_valid = 0; reg_write = 0;
    rd_sts("R3 set beats clear", 32'h2020);
    wr(STS, 32'h2000);
    rd_sts("R3 cleared after", 32'h20);
  endtask

  task automatic t_rx;
    rx_pkt_pending = 1;
    rd_sts("R4 rx pending", 32'h30);
    rx_pkt_pending = 0;
    rd_sts("R4 rx idle", 32'h20);
  endtask

  task automatic t_txe;
    txf_used = CW'(8);  rd_sts("R5 half at limit", 32'h20);
    txf_used = CW'(9);  rd_sts("R5 half above", 32'h0);
    txf_used = CW'(8); txq_has_room = 0; rd_sts("R5 no queue room", 32'h0);
    txq_has_room = 1; txe_full_sel = 1; txf_used = CW'(1);
    rd_sts("R5 full sel one word", 32'h0);
    txf_used = '0;      rd_sts("R5 full sel empty", 32'h20);
    txe_full_sel = 0;
  endtask

  task automatic t_otg;
    otg_sub_status = 8'h10;
    rd_sts("R6 otg or", 32'h24);
    wr(STS, 32'h4);
    rd_sts("R6 otg not w1c", 32'h24);
    otg_sub_status = 8'h0;
    rd_sts("R6 otg clear", 32'h20);
  endtask

  task automatic t_levels;
    gout_nak_eff = 1; gin_nak_eff = 1; host_mode = 1;
    rd_sts("R7 nak and mode", 32'hE1);
    wr(STS, 32'hC1);
    rd_sts("R7 read only", 32'hE1);
    gout_nak_eff = 0; gin_nak_eff = 0; host_mode = 0;
    rd_sts("R7 levels low", 32'h20);
  endtask

  task automatic t_mismatch;
    logic [31:0] d; logic dr;
    rd(12'h400, d, dr);
    chk("R8 host reg in device drop", {31'b0, dr}, 32'h1);
    chk("R8 dropped read zero", d, 32'h0);
    rd_sts("R8 mismatch set", 32'h22);
    wr(STS, 32'h2);
    rd(12'h800, d, dr);
    chk("R8 device reg in device ok", {31'b0, dr}, 32'h0);
    rd_sts("R8 no mismatch", 32'h20);
    host_mode = 1;
    @(negedge clk);
    rd(12'h400, d, dr);
    chk("R8 host reg in host ok", {31'b0, dr}, 32'h0);
    rd(12'h900, d, dr);
    chk("R8 device reg in host drop", {31'b0, dr}, 32'h1);
    rd_sts("R8 mismatch in host", 32'h23);
    wr(STS, 32'h2);
    host_mode = 0;
    rd_sts("R8 restored", 32'h20);
  endtask

  task automatic t_mask;
    logic [31:0] d; logic dr;
    wr(MSK, 32'hFFFF_FFFF);
    rd(MSK, d, dr); chk("R9 mask writable bits", d, 32'h3CFE);
    wr(MSK, 32'h8);
    @(negedge clk); ev_enum_done = 1;
    @(negedge clk); ev_enum_done = 0;
    @(negedge clk);
    chk("R9 masked bit no irq", {31'b0, irq}, 32'h0);
    rd_sts("R9 masked bit still sets", 32'h2020);
    @(negedge clk); ev_sof = 1;
    @(negedge clk); ev_sof = 0;
    chk("R9 irq one cycle later", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    wr(STS, 32'h8);
    chk("R9 irq holds until next edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    wr(MSK, 32'h20);
    @(negedge clk);
    chk("R9 level bit irq", {31'b0, irq}, 32'h1);
    wr(MSK, 32'h0);
    wr(STS, 32'h2000);
    @(negedge clk);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sticky();
    t_set_wins();
    t_rx();
    t_txe();
    t_otg();
    t_levels();
    t_mismatch();
    t_mask();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule